// File: doc/BRIEF.md
# Motor Control Register File

This block is the bus-facing register bank that sits between a host processor and a stepper or DC motor controller. The host reaches it through a 32-bit memory-mapped slave port with active-low chip select, read strobe and write strobe and a 3-bit word address. Inside sits an 8-bit control word, a 3-bit speed word and a 32-bit step count. The host can load the control word in one go. It can also turn individual control bits on or off through two alias addresses, with no read-modify-write on the bus. The bits of the control word drive the controller's run enable, direction and 4-bit mode. The speed word drives the 3-bit speed.

The motor controller reports back through a 32-bit step count and a request line. While the request line is high, the step count is captured on every clock edge. A request that arrives while interrupts are enabled latches a sticky pending flag, which raises the interrupt line until the host acknowledges it through the clear alias. Two 8-bit LED buses mirror the control word and the middle byte of the captured step count.

Reset is synchronous and active low. Read data is combinational and shows the selected register during the cycle in which chip select and read strobe are both low.

Top module: `mcr_regfile`

## Requirements
- R1: While reset is held low, every register clears on the clock edge. Afterwards every readable address returns 0, and run, direction, mode, speed, irq and both LED buses are 0.
- R2: A write to address 0 loads write data bits 7:0 into the control word. The control word layout is: bit 0 run, bit 1 direction, bits 5:2 mode, bit 6 interrupt enable, bit 7 interrupt pending. The run, direction and mode outputs and the green LEDs follow the control word from the next cycle. A read of address 0 returns the control word with bits 31:8 zero.
- R3: A write to address 1 ORs write data bits 7:0 into the control word.
- R4: A write to address 2 clears every control bit whose write data bit is 1 and leaves the other bits unchanged.
- R5: Reads of address 1 and address 2 return the control word.
- R6: A write to address 3 loads write data bits 2:0 into the speed word, which drives the speed output. A read of address 3 returns it zero-extended.
- R7: The step count loads from the steps input on every clock edge where the request input is high and holds otherwise. Bus writes to address 4 have no effect on it. A read of address 4 returns it, and the red LEDs show its bits 15:8.
- R8: When the request input is high at a clock edge and interrupt enable is 1, the pending bit is set by that edge and stays set. When interrupt enable is 0, a request leaves pending unchanged. The irq output is pending AND enable.
- R9: Writing 1 to bit 7 through address 2 acknowledges the interrupt and clears pending. If an enabled request arrives at the same edge, pending stays set.
- R10: Addresses 5, 6 and 7 read as 0, and writes to them change no register.
- R11: With chip select high, writes are ignored and read data is 0. With the read strobe high, read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, 0 when no read is active |
| irq | output | 1 | Interrupt to the host |
| led_green | output | 8 | Mirror of the control word |
| led_red | output | 8 | Bits 15:8 of the captured step count |
| run | output | 1 | Run enable to the motor controller |
| dir | output | 1 | Direction to the motor controller |
| mode | output | 4 | Mode bits to the motor controller |
| speed | output | 3 | Speed to the motor controller |
| steps_in | input | 32 | Step count from the motor controller |
| req | input | 1 | Request line from the motor controller |

## Verification
The alias assertions check only control bits 6:0 across a set or clear write. The reason is that a request arriving at the same edge may legally force bit 7, and the assertions assume nothing about when the request line moves. The pending and step-hold properties rely only on the request being sampled at the clock edge. The stimulus changes every input on the falling edge, so each bus access and each request pulse is stable across exactly one rising edge. The stimulus also raises the request in the same cycle as an acknowledge on purpose, to exercise the set-over-clear priority.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    localparam int MODE_W  = 4;
    localparam int CTRL_W  = MODE_W + 4;
    localparam int SPEED_W = 3;
    localparam int ADDR_W  = 3;

    // Address decode: the alias offsets are behaviour the host relies on
    localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_SET   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CLR   = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_SPEED = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_STEPS = 3'd4;

    // Control word, MSB first: pending, int enable, mode, direction, run
    typedef struct packed {
        logic              pend;
        logic              ie;
        logic [MODE_W-1:0] mode;
        logic              dir;
        logic              run;
    } ctrl_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_LOAD,
        OP_SET,
        OP_CLR
    } ctrl_op_e;

    function automatic ctrl_t apply_op(ctrl_t cur, ctrl_op_e op, logic [CTRL_W-1:0] d);
        ctrl_t res;
        case (op)
            OP_LOAD: res = ctrl_t'(d);
            OP_SET:  res = ctrl_t'(cur | d);
            OP_CLR:  res = ctrl_t'(cur & ~d);
            default: res = cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/mcr_decode.sv
module mcr_decode
    import mcr_pkg::*;
(
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output ctrl_op_e          ctrl_op,
    output logic              speed_we,
    output logic              rd_en
);

    logic wr_en;

    assign wr_en = !cs_n && !wr_n;
    assign rd_en = !cs_n && !rd_n;

    always_comb begin
        ctrl_op  = OP_NONE;
        speed_we = 1'b0;
        if (wr_en) begin
            case (addr)
                ADR_CTRL:  ctrl_op  = OP_LOAD;
                ADR_SET:   ctrl_op  = OP_SET;
                ADR_CLR:   ctrl_op  = OP_CLR;
                ADR_SPEED: speed_we = 1'b1;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/mcr_ctrl_reg.sv
module mcr_ctrl_reg
    import mcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_op_e          op,
    input  logic [CTRL_W-1:0] wbits,
    input  logic              req,
    output ctrl_t             q
);

    ctrl_t nxt;

    always_comb begin
        nxt = apply_op(q, op, wbits);
        // An enabled request outranks a same-cycle acknowledge
        if (req && q.ie)
            nxt.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= nxt;
    end

endmodule

// File: rtl/mcr_data_regs.sv
module mcr_data_regs #(
    parameter int SPEED_W = 3,
    parameter int STEPS_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               speed_we,
    input  logic [SPEED_W-1:0] speed_d,
    input  logic               cap,
    input  logic [STEPS_W-1:0] steps_d,
    output logic [SPEED_W-1:0] speed_q,
    output logic [STEPS_W-1:0] steps_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            speed_q <= '0;
            steps_q <= '0;
        end else begin
            if (speed_we)
                speed_q <= speed_d;
            if (cap)
                steps_q <= steps_d;
        end
    end

endmodule

// File: rtl/mcr_regfile.sv
module mcr_regfile
    import mcr_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int LED_W   = 8,
    parameter int RED_LSB = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 irq,
    output logic [LED_W-1:0]     led_green,
    output logic [LED_W-1:0]     led_red,
    output logic                 run,
    output logic                 dir,
    output logic [MODE_W-1:0]    mode,
    output logic [SPEED_W-1:0]   speed,
    input  logic [DATA_W-1:0]    steps_in,
    input  logic                 req
);

    ctrl_op_e          op;
    logic              speed_we;
    logic              rd_en;
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] steps_q;
    logic              unused_wbits;

    assign unused_wbits = ^wdata[DATA_W-1:CTRL_W];

    mcr_decode u_dec (
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .ctrl_op  (op),
        .speed_we (speed_we),
        .rd_en    (rd_en)
    );

    mcr_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .wbits (wdata[CTRL_W-1:0]),
        .req   (req),
        .q     (ctrl_q)
    );

    mcr_data_regs #(
        .SPEED_W (SPEED_W),
        .STEPS_W (DATA_W)
    ) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .speed_we (speed_we),
        .speed_d  (wdata[SPEED_W-1:0]),
        .cap      (req),
        .steps_d  (steps_in),
        .speed_q  (speed),
        .steps_q  (steps_q)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                ADR_CTRL, ADR_SET, ADR_CLR: rdata = DATA_W'(ctrl_q);
                ADR_SPEED:                  rdata = DATA_W'(speed);
                ADR_STEPS:                  rdata = steps_q;
                default:                    rdata = '0;
            endcase
        end
    end

    assign run       = ctrl_q.run;
    assign dir       = ctrl_q.dir;
    assign mode      = ctrl_q.mode;
    assign irq       = ctrl_q.pend && ctrl_q.ie;
    assign led_green = LED_W'(ctrl_q);
    assign led_red   = steps_q[RED_LSB +: LED_W];

endmodule

// File: rtl/mcr_regfile_chk.sv
module mcr_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        rd_n,
    input logic        wr_n,
    input logic [2:0]  addr,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic [7:0]  led_green,
    input logic [7:0]  led_red,
    input logic [2:0]  speed,
    input logic        req
);

    AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && addr == 3'd1) |=>
            led_green[6:0] == ($past(led_green[6:0]) | $past(wdata[6:0]))); // R3

    AST_CLR_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && addr == 3'd2) |=>
            led_green[6:0] == ($past(led_green[6:0]) & ~$past(wdata[6:0]))); // R4

    AST_SPEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && addr == 3'd3) |=> speed == $past(wdata[2:0])); // R6

    AST_STEPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(led_red)); // R7

    AST_PEND_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (req && led_green[6]) |=> led_green[7]); // R8

    AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && addr >= 3'd5) |-> rdata == 32'd0); // R10

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> rdata == 32'd0); // R11

endmodule

bind mcr_regfile mcr_regfile_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .led_green (led_green),
    .led_red   (led_red),
    .speed     (speed),
    .req       (req)
);

// File: tb/mcr_regfile_tb.sv
`timescale 1ns/1ps
module mcr_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [7:0]  led_green;
    logic [7:0]  led_red;
    logic        run;
    logic        dir;
    logic [3:0]  mode;
    logic [2:0]  speed;
    logic [31:0] steps_in = '0;
    logic        req = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mcr_regfile dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .irq       (irq),
        .led_green (led_green),
        .led_red   (led_red),
        .run       (run),
        .dir       (dir),
        .mode      (mode),
        .speed     (speed),
        .steps_in  (steps_in),
        .req       (req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one write across one rising edge, optionally with req
    task automatic bus_write(input logic [2:0] a, input logic [31:0] d, input logic with_req);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d; req = with_req;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; wdata = '0; req = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic pulse_req(input logic [31:0] s);
        @(negedge clk);
        steps_in = s; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            bus_read(3'(a), d);
            chk("R1 read after reset", d, 32'd0);
        end
        chk("R1 outputs", {run, dir, mode, speed, irq, led_green, led_red}, '0);
    endtask

    task automatic t_ctrl_write;
        logic [31:0] d;
        bus_write(3'd0, 32'hFFFF_FF2D, 1'b0);
        #1;
        chk("R2 run", {31'd0, run}, 32'd1);
        chk("R2 dir", {31'd0, dir}, 32'd0);
        chk("R2 mode", {28'd0, mode}, 32'hB);
        chk("R2 green", {24'd0, led_green}, 32'h2D);
        bus_read(3'd0, d);
        chk("R2 readback", d, 32'h2D);
    endtask

    task automatic t_set_alias;
        logic [31:0] d;
        bus_write(3'd1, 32'h0000_0042, 1'b0);
        bus_read(3'd1, d);
        chk("R3 R5 set alias read", d, 32'h6F);
        chk("R3 dir", {31'd0, dir}, 32'd1);
    endtask

    task automatic t_clr_alias;
        logic [31:0] d;
        bus_write(3'd2, 32'h0000_0005, 1'b0);
        bus_read(3'd2, d);
        chk("R4 R5 clear alias read", d, 32'h6A);
        chk("R4 run", {31'd0, run}, 32'd0);
    endtask

    task automatic t_speed;
        logic [31:0] d;
        bus_write(3'd3, 32'hFFFF_FFFD, 1'b0);
        #1 chk("R6 speed out", {29'd0, speed}, 32'd5);
        bus_read(3'd3, d);
        chk("R6 speed read", d, 32'd5);
    endtask

    task automatic t_steps_irq;
        logic [31:0] d;
        steps_in = 32'h1234_AB78;
        repeat (3) @(negedge clk);
        bus_read(3'd4, d);
        chk("R7 hold without req", d, 32'd0);
        pulse_req(32'h1234_AB78);
        steps_in = 32'hDEAD_BEEF;
        #1;
        chk("R7 red leds", {24'd0, led_red}, 32'hAB);
        chk("R8 irq raised", {31'd0, irq}, 32'd1);
        bus_write(3'd4, 32'h0000_0000, 1'b0);
        bus_read(3'd4, d);
        chk("R7 captured, write ignored", d, 32'h1234_AB78);
        repeat (4) @(negedge clk);
        #1 chk("R8 pending sticky", {24'd0, led_green}, 32'hEA);
    endtask

    task automatic t_ack;
        logic [31:0] d;
        bus_write(3'd2, 32'h0000_0080, 1'b0);
        #1 chk("R9 ack clears irq", {31'd0, irq}, 32'd0);
        bus_write(3'd2, 32'h0000_0080, 1'b1);
        #1 chk("R9 request beats ack", {24'd0, led_green}, 32'hEA);
        bus_write(3'd2, 32'h0000_00C0, 1'b0);
        bus_read(3'd0, d);
        chk("R9 ack and disable", d, 32'h2A);
        pulse_req(32'h1234_AB78);
        #1;
        chk("R8 disabled req no pend", {24'd0, led_green}, 32'h2A);
        chk("R8 disabled irq low", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_reserved;
        logic [31:0] d;
        for (int a = 5; a < 8; a++)
            bus_write(3'(a), 32'hFFFF_FFFF, 1'b0);
        bus_read(3'd0, d);
        chk("R10 ctrl untouched", d, 32'h2A);
        bus_read(3'd3, d);
        chk("R10 speed untouched", d, 32'd5);
        for (int a = 5; a < 8; a++) begin
            bus_read(3'(a), d);
            chk("R10 reserved read", d, 32'd0);
        end
    endtask

    task automatic t_no_select;
        logic [31:0] d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; rd_n = 1'b0; addr = 3'd0; wdata = 32'hFF;
        #1 chk("R11 read with cs high", rdata, 32'd0);
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b1; cs_n = 1'b0; wdata = '0;
        #1 chk("R11 read with rd high", rdata, 32'd0);
        cs_n = 1'b1;
        bus_read(3'd0, d);
        chk("R11 write ignored", d, 32'h2A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_write();
        t_set_alias();
        t_clr_alias();
        t_speed();
        t_steps_irq();
        t_ack();
        t_reserved();
        t_no_select();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule